// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This engine is the bit-level timing layer of a master for a single-wire open-drain bus that has a resistor pull-up. The engine never drives the wire high. It either pulls the wire low through `drive_low_o` or releases it, and the pull-up raises it again. The wire is read back on `line_i`, which passes through a two-flop synchroniser inside the block.

Software or a byte-level sequencer gives the engine one command at a time. The commands are a bus reset with presence detection, a write-one slot, a write-zero slot and a read slot. Each command starts with a start pulse while the engine is idle. The engine holds `busy_o` while the slot runs and signals the end with a one-cycle `done_o`. A read leaves its result on `bit_o`, and a reset leaves a three-valued result on `status_o`.

Every duration is a runtime input counted in microseconds. A divider turns the system clock into a microsecond tick, and that divider restarts whenever a command is accepted. A read slot stops sampling as soon as the wire is seen high and decides the bit from the elapsed time. A reset checks the wire for a stuck-low fault both before the pulse and after the presence window.

Top module: `owm_slot_engine`

## Requirements
- R1: The wire is only ever pulled low or released. `drive_low_o` is 0 whenever `busy_o` is 0, and it is 0 out of reset.
- R2: A start is accepted only when the engine is idle (`busy_o` = 0). A start raised while busy is ignored: the running slot keeps its timing and produces exactly one `done_o`.
- R3: Write-one (`cmd_i` = 01): the wire is pulled low for the write-one low time. `done_o` comes when the slot time plus the recovery time has passed since acceptance.
- R4: Write-zero (`cmd_i` = 10): the wire is pulled low for the write-zero low time. `done_o` comes when the slot time plus the recovery time has passed since acceptance.
- R5: Read (`cmd_i` = 11): the wire is pulled low for the read low time and then polled. `bit_o` = 1 if the wire is seen high while fewer than read-valid whole microseconds have passed since acceptance. Otherwise `bit_o` = 0, and polling stops at read-valid + 2 µs. `done_o` comes at slot time + recovery time.
- R6: Reset (`cmd_i` = 00) with the synchronised wire low at acceptance: no low pulse is made. `status_o` = 10 (wiring error) and `done_o` comes in the cycle after acceptance.
- R7: Reset on a healthy wire: the wire is pulled low for the reset low time and then released. It is sampled at reset-low + presence-wait + presence-length/2. `status_o` = 01 if the wire is low there and 00 if it is high. `done_o` comes at reset-low + reset-high time.
- R8: If the wire is low when the reset's high time ends, `status_o` = 10, whatever presence was seen earlier.
- R9: One microsecond is `div_i`+1 clock cycles (`div_i` ≥ 3), counted from the acceptance edge. A duration of N µs therefore lasts exactly N·(`div_i`+1) cycles. Every duration input is at least 1.
- R10: `done_o` is a one-cycle pulse that falls in the cycle in which `busy_o` falls. A start raised in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Clock cycles per microsecond minus one |
| wr1_low_us_i | input | TW | Low time of a write-one slot |
| wr0_low_us_i | input | TW | Low time of a write-zero slot |
| rd_low_us_i | input | TW | Low time of a read slot |
| rd_valid_us_i | input | TW | Read decision limit from slot start |
| slot_us_i | input | TW | Slot length |
| recov_us_i | input | TW | Recovery time after a slot |
| rst_low_us_i | input | TW | Reset low time |
| pres_wait_us_i | input | TW | Wait after release before the presence pulse |
| pres_len_us_i | input | TW | Presence pulse length |
| rst_high_us_i | input | TW | Reset high time from release to end |
| start_i | input | 1 | Command request |
| cmd_i | input | 2 | 00 reset, 01 write-one, 10 write-zero, 11 read |
| line_i | input | 1 | Wire level from the pad |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| drive_low_o | output | 1 | Pull the wire low when 1, release when 0 |
| bit_o | output | 1 | Result of the last read slot |
| status_o | output | 2 | Last reset result: 00 no device, 01 present, 10 wiring error |

## Verification
Two pairs of events can land in the same cycle. The first pair is the completion of one command and the acceptance of the next. The bench provokes this by raising start in the very cycle `done_o` is seen, and it judges the second slot by its exact low time and end time. The second pair is a read slot where the released wire reaches the synchroniser just as the elapsed microsecond count reaches read-valid. The bench places the slave's release at read-valid − 1 µs and at read-valid µs, and it expects the bit to flip between those two cases.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    CMD_RESET = 2'b00,
    CMD_WR1   = 2'b01,
    CMD_WR0   = 2'b10,
    CMD_READ  = 2'b11
  } owm_cmd_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_PRESENT = 2'b01,
    RES_WIREERR = 2'b10
  } owm_res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_POLL,
    S_TAIL,
    S_XLOW,
    S_XPD,
    S_XEND
  } owm_state_e;

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = en_i && (cnt_q == div_i);
    if (clr_i || tick_o || !en_i) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o
);

  logic [STAGES-1:0] sh_q, sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = line_i;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign line_s_o = sh_q[STAGES-1];

endmodule

// File: rtl/owm_slot_fsm.sv
module owm_slot_fsm
  import owm_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    cmd_i,
  input  logic          tick_i,
  input  logic          line_s_i,
  input  logic [TW-1:0] wr1_low_i,
  input  logic [TW-1:0] wr0_low_i,
  input  logic [TW-1:0] rd_low_i,
  input  logic [TW-1:0] rd_valid_i,
  input  logic [TW-1:0] slot_i,
  input  logic [TW-1:0] recov_i,
  input  logic [TW-1:0] rst_low_i,
  input  logic [TW-1:0] pres_wait_i,
  input  logic [TW-1:0] pres_len_i,
  input  logic [TW-1:0] rst_high_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          drive_low_o,
  output logic          bit_o,
  output logic [1:0]    status_o,
  output logic          clr_o
);

  localparam int UW = TW + 2;

  owm_state_e    st_q, st_d;
  owm_cmd_e      cmd_q, cmd_d;
  owm_res_e      res_q, res_d;
  logic [UW-1:0] us_q, us_d, us_nx;
  logic          done_q, done_d;
  logic          drv_q, drv_d;
  logic          bit_q, bit_d;
  logic [UW-1:0] lim_low, lim_poll, lim_slot, lim_rstl, lim_samp, lim_rend;

  function automatic logic [UW-1:0] ext(input logic [TW-1:0] v);
    return {{(UW-TW){1'b0}}, v};
  endfunction

  assign us_nx = us_q + 1'b1;

  // Limits are absolute microsecond counts from the acceptance edge.
  always_comb begin
    lim_slot = ext(slot_i) + ext(recov_i);
    lim_poll = ext(rd_valid_i) + UW'(2);
    lim_rstl = ext(rst_low_i);
    lim_samp = ext(rst_low_i) + ext(pres_wait_i) + ext(pres_len_i >> 1);
    lim_rend = ext(rst_low_i) + ext(rst_high_i);
    case (cmd_q)
      CMD_WR1: lim_low = ext(wr1_low_i);
      CMD_WR0: lim_low = ext(wr0_low_i);
      default: lim_low = ext(rd_low_i);
    endcase
  end

  function automatic logic reached(input logic [UW-1:0] lim);
    return (us_q >= lim) || (tick_i && (us_nx >= lim));
  endfunction

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    res_d  = res_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    clr_o  = 1'b0;
    us_d   = tick_i ? us_nx : us_q;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          clr_o = 1'b1;
          us_d  = '0;
          cmd_d = owm_cmd_e'(cmd_i);
          if (owm_cmd_e'(cmd_i) == CMD_RESET) begin
            if (!line_s_i) begin
              res_d  = RES_WIREERR;
              done_d = 1'b1;
            end else begin
              st_d = S_XLOW;
            end
          end else begin
            st_d = S_LOW;
          end
        end
      end
      S_LOW: begin
        if (reached(lim_low)) st_d = (cmd_q == CMD_READ) ? S_POLL : S_TAIL;
      end
      S_POLL: begin
        if (line_s_i) begin
          bit_d = (us_q < ext(rd_valid_i));
          st_d  = S_TAIL;
        end else if (reached(lim_poll)) begin
          bit_d = 1'b0;
          st_d  = S_TAIL;
        end
      end
      S_TAIL: begin
        if (reached(lim_slot)) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end
      end
      S_XLOW: begin
        if (reached(lim_rstl)) st_d = S_XPD;
      end
      S_XPD: begin
        if (reached(lim_samp)) begin
          res_d = line_s_i ? RES_NONE : RES_PRESENT;
          st_d  = S_XEND;
        end
      end
      S_XEND: begin
        if (reached(lim_rend)) begin
          if (!line_s_i) res_d = RES_WIREERR;
          st_d   = S_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    drv_d = (st_d == S_LOW) || (st_d == S_XLOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cmd_q  <= CMD_RESET;
      res_q  <= RES_NONE;
      us_q   <= '0;
      done_q <= 1'b0;
      drv_q  <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      res_q  <= res_d;
      us_q   <= us_d;
      done_q <= done_d;
      drv_q  <= drv_d;
      bit_q  <= bit_d;
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign drive_low_o = drv_q;
  assign bit_o       = bit_q;
  assign status_o    = res_q;

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine #(
  parameter int DIV_W  = 8,
  parameter int TW     = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TW-1:0]    wr1_low_us_i,
  input  logic [TW-1:0]    wr0_low_us_i,
  input  logic [TW-1:0]    rd_low_us_i,
  input  logic [TW-1:0]    rd_valid_us_i,
  input  logic [TW-1:0]    slot_us_i,
  input  logic [TW-1:0]    recov_us_i,
  input  logic [TW-1:0]    rst_low_us_i,
  input  logic [TW-1:0]    pres_wait_us_i,
  input  logic [TW-1:0]    pres_len_us_i,
  input  logic [TW-1:0]    rst_high_us_i,
  input  logic             start_i,
  input  logic [1:0]       cmd_i,
  input  logic             line_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             drive_low_o,
  output logic             bit_o,
  output logic [1:0]       status_o
);

  logic tick;
  logic clr;
  logic line_s;

  owm_line_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .line_s_o (line_s)
  );

  owm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .en_i   (busy_o),
    .div_i  (div_i),
    .tick_o (tick)
  );

  owm_slot_fsm #(.TW(TW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .tick_i      (tick),
    .line_s_i    (line_s),
    .wr1_low_i   (wr1_low_us_i),
    .wr0_low_i   (wr0_low_us_i),
    .rd_low_i    (rd_low_us_i),
    .rd_valid_i  (rd_valid_us_i),
    .slot_i      (slot_us_i),
    .recov_i     (recov_us_i),
    .rst_low_i   (rst_low_us_i),
    .pres_wait_i (pres_wait_us_i),
    .pres_len_i  (pres_len_us_i),
    .rst_high_i  (rst_high_us_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .drive_low_o (drive_low_o),
    .bit_o       (bit_o),
    .status_o    (status_o),
    .clr_o       (clr)
  );

endmodule

// File: rtl/owm_slot_chk.sv
module owm_slot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] cmd_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       drive_low_o,
  input logic       bit_o,
  input logic [1:0] status_o,
  input logic       line_s
);

  // R1
  drive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !drive_low_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);

  // R10
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o || done_o));

  // R6
  stuck_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && cmd_i == 2'b00 && !line_s) |=>
      (done_o && status_o == 2'b10 && !drive_low_o && !busy_o));

  // R7
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b11);

  // R5
  bit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_o) |-> busy_o);

endmodule

bind owm_slot_engine owm_slot_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmd_i       (cmd_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .drive_low_o (drive_low_o),
  .bit_o       (bit_o),
  .status_o    (status_o),
  .line_s      (line_s)
);

// File: tb/tb_owm_slot_engine.sv
`timescale 1ns/1ps
module tb_owm_slot_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] cmd_i = 2'b00;
  logic line_i;
  logic busy_o, done_o, drive_low_o, bit_o;
  logic [1:0] status_o;

  int d_div = 3;
  int p_wr1 = 2, p_wr0 = 15, p_rdl = 1, p_rdv = 10, p_slot = 25, p_rec = 2;
  int p_rstl = 30, p_pdh = 3, p_pdl = 10, p_rsth = 40;

  int n = 0;
  int smode = 0;
  int hold_us = 0;
  logic slave_low;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  owm_slot_engine dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .div_i          (d_div[7:0]),
    .wr1_low_us_i   (p_wr1[9:0]),
    .wr0_low_us_i   (p_wr0[9:0]),
    .rd_low_us_i    (p_rdl[9:0]),
    .rd_valid_us_i  (p_rdv[9:0]),
    .slot_us_i      (p_slot[9:0]),
    .recov_us_i     (p_rec[9:0]),
    .rst_low_us_i   (p_rstl[9:0]),
    .pres_wait_us_i (p_pdh[9:0]),
    .pres_len_us_i  (p_pdl[9:0]),
    .rst_high_us_i  (p_rsth[9:0]),
    .start_i        (start_i),
    .cmd_i          (cmd_i),
    .line_i         (line_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .drive_low_o    (drive_low_o),
    .bit_o          (bit_o),
    .status_o       (status_o)
  );

  // Slave model: 0 idle, 1 read hold, 2 presence, 3 stuck low, 4 stuck from presence onward
  always_comb begin
    case (smode)
      1:       slave_low = (n < hold_us * (d_div + 1));
      2:       slave_low = (n >= (p_rstl + p_pdh) * (d_div + 1)) &&
                           (n <  (p_rstl + p_pdh + p_pdl) * (d_div + 1));
      3:       slave_low = 1'b1;
      4:       slave_low = (n >= (p_rstl + p_pdh) * (d_div + 1));
      default: slave_low = 1'b0;
    endcase
  end
  assign line_i = !(drive_low_o || slave_low);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // mode: slave behaviour, hold: read hold in us, poke: cycle of a start while busy (-1 none)
  task automatic do_cmd(input int c, input int mode, input int hold, input int poke, input bit settle);
    int lowc, exp_t, exp_low, exp_v, u;
    string tag;
    n = 0;
    smode = mode;
    hold_us = hold;
    if (settle) repeat (4) @(negedge clk);
    cmd_i = c[1:0];
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    lowc = 0;
    while (!done_o && n < 40000) begin
      if (drive_low_o) lowc++;
      if (n == poke) begin
        start_i = 1'b1;
        cmd_i = ~c[1:0];
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    u = d_div + 1;
    exp_v = 0;
    case (c)
      0: begin
        if (mode == 3) begin
          exp_t = 0; exp_low = 0; exp_v = 2; tag = "R6";
        end else begin
          exp_t = (p_rstl + p_rsth) * u;
          exp_low = p_rstl * u;
          exp_v = (mode == 2) ? 1 : ((mode == 4) ? 2 : 0);
          tag = (mode == 4) ? "R8" : "R7";
        end
      end
      1: begin exp_t = (p_slot + p_rec) * u; exp_low = p_wr1 * u; tag = "R3"; end
      2: begin exp_t = (p_slot + p_rec) * u; exp_low = p_wr0 * u; tag = "R4"; end
      default: begin
        exp_t = (p_slot + p_rec) * u; exp_low = p_rdl * u;
        exp_v = (hold < p_rdv) ? 1 : 0; tag = "R5";
      end
    endcase
    if (poke >= 0) tag = {tag, " R2"};
    chk(n == exp_t, {tag, " R9 done time"}, n, exp_t);
    chk(lowc == exp_low, {tag, " R9 low time"}, lowc, exp_low);
    if (c == 0) chk(int'(status_o) == exp_v, {tag, " status"}, int'(status_o), exp_v);
    if (c == 3) chk(int'(bit_o) == exp_v, {tag, " read bit"}, int'(bit_o), exp_v);
    if (poke >= 0) begin
      @(negedge clk);
      chk(!done_o && !busy_o, "R2 ignored start left no second command", int'(busy_o), 0);
    end
  endtask

  task automatic randomize_timing();
    d_div = rnd(3, 5);
    p_wr1 = rnd(1, 4);   p_wr0 = rnd(10, 20); p_rdl = rnd(1, 2);
    p_rdv = rnd(8, 12);  p_slot = rnd(25, 30); p_rec = rnd(1, 3);
    p_rstl = rnd(20, 40); p_pdh = rnd(2, 5); p_pdl = rnd(8, 16); p_rsth = rnd(30, 45);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary_and_end();
  end

  initial begin
    int seed_v, c, m, h, pk;
    seed_v = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy_o, "R1 reset busy", int'(busy_o), 0);
    chk(!done_o, "R10 reset done", int'(done_o), 0);
    chk(!drive_low_o, "R1 reset drive", int'(drive_low_o), 0);
    chk(status_o == 2'b00, "R7 reset status", int'(status_o), 0);
    chk(!bit_o, "R5 reset bit", int'(bit_o), 0);

    // directed corner cases
    do_cmd(0, 2, 0, -1, 1);            // R7 presence
    do_cmd(0, 0, 0, -1, 1);            // R7 no device
    do_cmd(0, 3, 0, -1, 1);            // R6 stuck before
    do_cmd(0, 4, 0, -1, 1);            // R8 stuck after window
    do_cmd(1, 0, 0, 7, 1);             // R3 with ignored start (R2)
    do_cmd(2, 0, 0, 20, 1);            // R4 with ignored start (R2)
    do_cmd(3, 1, p_rdv - 1, -1, 1);    // R5 boundary, bit 1
    do_cmd(3, 1, p_rdv, -1, 1);        // R5 boundary, bit 0
    do_cmd(3, 1, p_rdv + 4, -1, 1);    // R5 timeout path
    do_cmd(3, 0, 0, -1, 1);            // R5 no slave
    do_cmd(2, 0, 0, -1, 1);            // R10 back-to-back pair
    do_cmd(3, 1, p_rdv - 2, -1, 0);
    do_cmd(0, 2, 0, -1, 0);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      randomize_timing();
      c = rnd(0, 3);
      pk = (rnd(0, 3) == 0) ? 5 : -1;
      h = 0;
      m = 0;
      if (c == 0) begin
        case (rnd(0, 3))
          0: m = 0; 1: m = 2; 2: m = 3; default: m = 4;
        endcase
        if (m == 3) pk = -1;
      end else if (c == 3) begin
        m = 1;
        case (rnd(0, 3))
          0: h = 0; 1: h = p_rdv - 1; 2: h = p_rdv; default: h = p_rdv + 4;
        endcase
      end
      do_cmd(c, m, h, pk, 1);
    end
    smode = 0;
    repeat (4) @(negedge clk);
    summary_and_end();
  end

endmodule